// File: doc/BRIEF.md
# Accumulator Operation Unit with Condition Flags

This block is the purely combinational arithmetic/logic slice of a small accumulator machine. In the same evaluation it takes an operation code, the accumulator value, a second operand and the current condition flags. It returns the operation result and the next value of each flag. Each operation has its own flag policy. Some flags are recomputed from the result. Some are forced to a fixed value. The rest are passed through untouched, so the surrounding sequencer can write the flag register on every cycle without any per-operation masking.

The supported operations are pass-through, two's-complement negation, nibble exchange, inclusive OR with the accumulator, and rotations through carry in both directions. Every operation except the OR works on the second operand. The two spare operation codes act as pass-through. The operand width is a parameter. It must be even, so that the nibble exchange can split the operand into two halves.

Top module: `alu8_acc_core`

## Requirements
- R1: With op code 0 (pass), `result` equals `opnd_in` and `flags_out` equals `flags_in`. The flag vector is ordered {V,H,I,N,Z,C} from bit 5 down to bit 0.
- R2: With op code 1 (negate), `result` equals 0 minus `opnd_in`, modulo 2^WIDTH.
- R3: For negate, C is set exactly when the result is nonzero. V is set exactly when the result is 0x80, the value with only the top bit set. H and I keep their incoming values.
- R4: With op code 2 (nibble exchange), the low half of `opnd_in` appears in the upper half of `result`, and the high half of `opnd_in` appears in the lower half.
- R5: Nibble exchange leaves all six flags equal to `flags_in`.
- R6: With op code 3 (OR), `result` is `acc_in | opnd_in`. V is cleared, and H, I and C keep their incoming values.
- R7: With op code 4 (rotate left through carry), `result` is `{opnd_in[6:0], C_in}` and the new C is `opnd_in[7]`.
- R8: With op code 5 (rotate right through carry), `result` is `{C_in, opnd_in[7:1]}` and the new C is `opnd_in[0]`.
- R9: For both rotations, the new V equals the new N XOR the new C, and H and I keep their incoming values.
- R10: For negate, OR and both rotations, N equals the top bit of `result`, and Z is set only when `result` is zero.
- R11: Op codes 6 and 7 behave exactly like op code 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 3 | Operation code (0 pass, 1 negate, 2 nibble exchange, 3 OR, 4 rotate left, 5 rotate right) |
| acc_in | input | WIDTH (8) | Accumulator value, used by OR only |
| opnd_in | input | WIDTH (8) | Second operand |
| flags_in | input | 6 | Incoming flags {V,H,I,N,Z,C} |
| result | output | WIDTH (8) | Operation result |
| flags_out | output | 6 | Next flags {V,H,I,N,Z,C} |

## Verification
The embedded checks are immediate assertions, evaluated whenever the inputs change. They assume that every input is a known 0 or 1, and that the operation code, operands and flags change together as a single coherent vector. The stimulus changes all inputs at one point per clock, away from the sampling point. It drives only fully known values. It sweeps every operation code, including the two spare ones, across all 256 operand values with both carry-in values. The other incoming flags are derived from the operand bits, so that bits passed through unchanged toggle in both directions.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

   typedef enum logic [2:0] {
      OP_PASS  = 3'd0,
      OP_NEG   = 3'd1,
      OP_NSWAP = 3'd2,
      OP_OR    = 3'd3,
      OP_ROL   = 3'd4,
      OP_ROR   = 3'd5,
      OP_SPARE6 = 3'd6,
      OP_SPARE7 = 3'd7
   } alu_op_e;

   typedef struct packed {
      logic v;
      logic h;
      logic i;
      logic n;
      logic z;
      logic c;
   } ccr_t;

   // How the flag register is written by the selected operation
   typedef enum logic [1:0] {
      FL_KEEP  = 2'd0,   // every flag passes through
      FL_LOGIC = 2'd1,   // V cleared, N/Z computed, H/I/C kept
      FL_ARITH = 2'd2    // V/N/Z/C computed, H/I kept
   } fl_mode_e;

   typedef enum logic [1:0] {
      SRC_PASS  = 2'd0,
      SRC_UNARY = 2'd1,
      SRC_OR    = 2'd2
   } src_sel_e;

endpackage

// File: rtl/alu8_decode.sv
module alu8_decode
   import alu8_pkg::*;
(
   input  alu_op_e  op,
   output src_sel_e src,
   output fl_mode_e fmode
);

   always_comb begin
      src   = SRC_PASS;
      fmode = FL_KEEP;
      unique case (op)
         OP_NEG, OP_ROL, OP_ROR: begin
            src   = SRC_UNARY;
            fmode = FL_ARITH;
         end
         OP_NSWAP: begin
            src   = SRC_UNARY;
            fmode = FL_KEEP;
         end
         OP_OR: begin
            src   = SRC_OR;
            fmode = FL_LOGIC;
         end
         default: begin
            src   = SRC_PASS;
            fmode = FL_KEEP;
         end
      endcase
   end

endmodule

// File: rtl/alu8_unary_unit.sv
module alu8_unary_unit
   import alu8_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  alu_op_e          op,
   input  logic [WIDTH-1:0] opnd,
   input  logic             c_in,
   output logic [WIDTH-1:0] res,
   output logic             c_new,
   output logic             v_new
);

   localparam int HALF = WIDTH / 2;
   localparam logic [WIDTH-1:0] MSB_ONLY = {1'b1, {(WIDTH-1){1'b0}}};

   logic [WIDTH-1:0] swapped;

   genvar gi;
   generate
      for (gi = 0; gi < HALF; gi++) begin : g_swap
         assign swapped[gi + HALF] = opnd[gi];
         assign swapped[gi]        = opnd[gi + HALF];
      end
   endgenerate

   always_comb begin
      res   = opnd;
      c_new = c_in;
      v_new = 1'b0;
      unique case (op)
         OP_NEG: begin
            res   = '0 - opnd;
            c_new = |res;
            v_new = (res == MSB_ONLY);
         end
         OP_ROL: begin
            res   = {opnd[WIDTH-2:0], c_in};
            c_new = opnd[WIDTH-1];
            v_new = res[WIDTH-1] ^ c_new;
         end
         OP_ROR: begin
            res   = {c_in, opnd[WIDTH-1:1]};
            c_new = opnd[0];
            v_new = res[WIDTH-1] ^ c_new;
         end
         OP_NSWAP: res = swapped;
         default: ;
      endcase
   end

   // R2: negation leaves operand plus result equal to zero
   always_comb begin
      if (op == OP_NEG) begin
         a_neg_sum_r2: assert (WIDTH'(res + opnd) == '0);
      end
   end

endmodule

// File: rtl/alu8_ccr_merge.sv
module alu8_ccr_merge
   import alu8_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  fl_mode_e         fmode,
   input  logic [WIDTH-1:0] res,
   input  logic             v_new,
   input  logic             c_new,
   input  ccr_t             ccr_in,
   output ccr_t             ccr_out
);

   logic n_calc;
   logic z_calc;

   assign n_calc = res[WIDTH-1];
   assign z_calc = (res == '0);

   always_comb begin
      ccr_out = ccr_in;
      unique case (fmode)
         FL_LOGIC: begin
            ccr_out.v = 1'b0;
            ccr_out.n = n_calc;
            ccr_out.z = z_calc;
         end
         FL_ARITH: begin
            ccr_out.v = v_new;
            ccr_out.n = n_calc;
            ccr_out.z = z_calc;
            ccr_out.c = c_new;
         end
         default: ;
      endcase
   end

   // H and I are never written by any operation
   always_comb begin
      a_hi_kept_r9: assert (ccr_out.h == ccr_in.h && ccr_out.i == ccr_in.i);
      if (fmode != FL_KEEP) begin
         a_z_zero_r10: assert (ccr_out.z == ~|res);
      end
   end

endmodule

// File: rtl/alu8_acc_core.sv
module alu8_acc_core
   import alu8_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic [2:0]       op_sel,
   input  logic [WIDTH-1:0] acc_in,
   input  logic [WIDTH-1:0] opnd_in,
   input  logic [5:0]       flags_in,
   output logic [WIDTH-1:0] result,
   output logic [5:0]       flags_out
);

   localparam logic [WIDTH-1:0] MSB_ONLY = {1'b1, {(WIDTH-1){1'b0}}};

   generate
      if (WIDTH < 2 || (WIDTH % 2) != 0) begin : g_bad_width
         $error("alu8_acc_core: WIDTH must be even and at least 2");
      end
   endgenerate

   alu_op_e          op;
   src_sel_e         src;
   fl_mode_e         fmode;
   ccr_t             ccr_in;
   ccr_t             ccr_out;
   logic [WIDTH-1:0] unary_res;
   logic             c_new;
   logic             v_new;

   assign op     = alu_op_e'(op_sel);
   assign ccr_in = ccr_t'(flags_in);

   alu8_decode u_dec (
      .op    (op),
      .src   (src),
      .fmode (fmode)
   );

   alu8_unary_unit #(.WIDTH(WIDTH)) u_unary (
      .op    (op),
      .opnd  (opnd_in),
      .c_in  (ccr_in.c),
      .res   (unary_res),
      .c_new (c_new),
      .v_new (v_new)
   );

   always_comb begin
      unique case (src)
         SRC_UNARY: result = unary_res;
         SRC_OR:    result = acc_in | opnd_in;
         default:   result = opnd_in;
      endcase
   end

   alu8_ccr_merge #(.WIDTH(WIDTH)) u_ccr (
      .fmode   (fmode),
      .res     (result),
      .v_new   (v_new),
      .c_new   (c_new),
      .ccr_in  (ccr_in),
      .ccr_out (ccr_out)
   );

   assign flags_out = ccr_out;

   always_comb begin
      if (op == OP_PASS || op == OP_SPARE6 || op == OP_SPARE7) begin
         a_pass_keep_r1: assert (result == opnd_in && flags_out == flags_in);
      end
      if (op == OP_NEG) begin
         a_neg_flags_r3: assert (ccr_out.c == (opnd_in != '0) &&
                                 ccr_out.v == (opnd_in == MSB_ONLY));
      end
      if (op == OP_NSWAP) begin
         a_swap_flags_r5: assert (flags_out == flags_in);
      end
      if (op == OP_OR) begin
         a_or_flags_r6: assert (!ccr_out.v && ccr_out.c == ccr_in.c);
      end
      if (op == OP_ROL || op == OP_ROR) begin
         a_rot_v_r9: assert (ccr_out.v == (ccr_out.n ^ ccr_out.c));
      end
   end

endmodule

// File: tb/sim_alu8_acc_core.sv
module sim_alu8_acc_core;

   typedef struct {
      logic [7:0] res;
      logic [5:0] flg;
      logic       upd_nz;
      string      tag_res;
      string      tag_flg;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [2:0] op_sel = '0;
   logic [7:0] acc_in = '0;
   logic [7:0] opnd_in = '0;
   logic [5:0] flags_in = '0;
   logic [7:0] result;
   logic [5:0] flags_out;

   int checks = 0;
   int fails  = 0;
   exp_t q[$];
   bit   done = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   alu8_acc_core u0 (
      .op_sel    (op_sel),
      .acc_in    (acc_in),
      .opnd_in   (opnd_in),
      .flags_in  (flags_in),
      .result    (result),
      .flags_out (flags_out)
   );

   // Reference from the requirements; flags {V,H,I,N,Z,C}
   task automatic ref_model(input logic [2:0] op, input logic [7:0] a,
                            input logic [7:0] m, input logic [5:0] f,
                            output exp_t e);
      logic v, h, i, n, z, c;
      logic [7:0] r;
      {v, h, i, n, z, c} = f;
      r = m;
      e.upd_nz = 1'b1;
      case (op)
         3'd1: begin r = 8'(9'h100 - {1'b0, m}); c = (r != 0); v = (r == 8'h80);
               e.tag_res = "R2"; e.tag_flg = "R3"; end
         3'd2: begin r = {m[3:0], m[7:4]}; e.upd_nz = 1'b0;
               e.tag_res = "R4"; e.tag_flg = "R5"; end
         3'd3: begin r = a | m; v = 1'b0; e.tag_res = "R6"; e.tag_flg = "R6"; end
         3'd4: begin r = {m[6:0], c}; c = m[7]; v = r[7] ^ c;
               e.tag_res = "R7"; e.tag_flg = "R9"; end
         3'd5: begin r = {c, m[7:1]}; c = m[0]; v = r[7] ^ c;
               e.tag_res = "R8"; e.tag_flg = "R9"; end
         3'd0: begin e.upd_nz = 1'b0; e.tag_res = "R1"; e.tag_flg = "R1"; end
         default: begin e.upd_nz = 1'b0; e.tag_res = "R11"; e.tag_flg = "R11"; end
      endcase
      if (e.upd_nz) begin
         n = r[7];
         z = (r == 8'h00);
      end
      e.res = r;
      e.flg = {v, h, i, n, z, c};
   endtask

   task automatic drive(input logic [2:0] op, input logic [7:0] a,
                        input logic [7:0] m, input logic [5:0] f);
      exp_t e;
      @(negedge clk);
      op_sel = op; acc_in = a; opnd_in = m; flags_in = f;
      ref_model(op, a, m, f, e);
      q.push_back(e);
   endtask

   // Monitor: compare one expected item per clock, after the edge
   always @(posedge clk) begin
      #1;
      if (!rst && q.size() > 0) begin
         exp_t e;
         string nz_tag;
         e = q.pop_front();
         nz_tag = e.upd_nz ? "R10" : e.tag_flg;
         checks++;
         if (result !== e.res) begin
            fails++;
            $display("FAIL %s op=%0d opnd=%02h result actual=%02h expected=%02h",
                     e.tag_res, op_sel, opnd_in, result, e.res);
         end
         checks++;
         if (flags_out[2:1] !== e.flg[2:1]) begin
            fails++;
            $display("FAIL %s op=%0d opnd=%02h N/Z actual=%b expected=%b",
                     nz_tag, op_sel, opnd_in, flags_out[2:1], e.flg[2:1]);
         end
         checks++;
         if ({flags_out[5:3], flags_out[0]} !== {e.flg[5:3], e.flg[0]}) begin
            fails++;
            $display("FAIL %s op=%0d opnd=%02h V/H/I/C actual=%b expected=%b",
                     e.tag_flg, op_sel, opnd_in,
                     {flags_out[5:3], flags_out[0]}, {e.flg[5:3], e.flg[0]});
         end
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      // Reset state, pass op with all-zero inputs (R1)
      drive(3'd0, 8'h00, 8'h00, 6'b000000);
      // Sweep: every op incl. spare codes (R11), all operands, both carries
      for (int op = 0; op < 8; op++) begin
         for (int m = 0; m < 256; m++) begin
            for (int c = 0; c < 2; c++) begin
               logic [7:0] mv;
               logic [7:0] av;
               mv = 8'(m);
               av = 8'((m * 37 + 11 + c * 90) & 255);
               drive(3'(op), av, mv,
                     {mv[0] ^ c[0], mv[1], ~mv[2], mv[3] ^ mv[5], ~mv[4], c[0]});
            end
         end
      end
      // Corner values for negate (R3) and OR with both zero (R10)
      drive(3'd1, 8'h00, 8'h80, 6'b011111);
      drive(3'd1, 8'h00, 8'h00, 6'b100001);
      drive(3'd3, 8'h00, 8'h00, 6'b111101);
      wait (q.size() == 0);
      @(negedge clk);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule